// File: doc/BRIEF.md
# Gated Daughterboard Bus Bridge

This block links an 8-bit processor expansion bus to a removable daughterboard. It passes six address bits, a read strobe, a write strobe and a bidirectional data byte across the link. A software-written control byte holds two fields. One is an enable flag that powers the daughterboard and switches on the drivers. The other is a level for a spare control line that runs to the board.

With the enable flag clear, every pin on the daughterboard side floats, so a board without power is never back-driven. With the flag set and the bus chip select inactive, the bridge holds both strobes high and the address at zero, and it drives neither data side. During a selected cycle, the strobe that is active sets the direction of the data. A selected cycle with no valid strobe pattern is treated as idle.

Every pin that can float comes out as a value plus an output-enable, and the pad ring resolves the pair. A status byte reports the enable flag and the level actually present on the spare line.

Top module: `db_bridge`

## Requirements
- R1: After reset (rst_ni low), the control byte is 0: power_o is 0, every daughterboard output-enable is 0, and cfg_rdata_o reads 8'h00.
- R2: While the enable flag is 0, db_ctl_oe_o, db_data_oe_o, db_spare_oe_o and eb_data_oe_o are all 0, whatever the bus inputs are.
- R3: While enabled with eb_cs_ni high, db_ctl_oe_o is 1, db_rd_no and db_wr_no are 1, db_addr_o is 0, and both data output-enables are 0.
- R4: While enabled with eb_cs_ni=0, eb_oe_ni=0 and eb_we_ni=1, db_rd_no is 0, db_wr_no is 1 and db_addr_o equals eb_addr_i. Also eb_data_oe_o=1 with eb_data_o=db_data_i, and db_data_oe_o=0.
- R5: While enabled with eb_cs_ni=0, eb_we_ni=0 and eb_oe_ni=1, db_wr_no is 0, db_rd_no is 1 and db_addr_o equals eb_addr_i. Also db_data_oe_o=1 with db_data_o=eb_data_i, and eb_data_oe_o=0.
- R6: A selected cycle (eb_cs_ni=0) with both strobes low, or with both strobes high, behaves as idle: both strobes high, address 0, and neither data output-enable set.
- R7: db_spare_oe_o equals the enable flag, and db_spare_o equals the spare-level field.
- R8: A cycle with cfg_we_i high loads the control byte on the next rising clock edge. Bit 1 is the enable flag and bit 4 is the spare level, and all other bits are ignored.
- R9: cfg_rdata_o has bit 1 equal to the enable flag and bit 4 equal to db_spare_i, the sensed spare-line level. All other bits are 0.
- R10: eb_data_oe_o and db_data_oe_o are never 1 together.
- R11: power_o equals the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Status byte |
| eb_cs_ni | input | 1 | Bus chip select, active low |
| eb_oe_ni | input | 1 | Bus read strobe, active low |
| eb_we_ni | input | 1 | Bus write strobe, active low |
| eb_addr_i | input | 6 | Bus low address bits |
| eb_data_i | input | 8 | Resolved bus data level |
| eb_data_o | output | 8 | Data driven onto the bus |
| eb_data_oe_o | output | 1 | Bus data output-enable |
| db_ctl_oe_o | output | 1 | Output-enable for the daughterboard strobes and address |
| db_rd_no | output | 1 | Daughterboard read strobe, active low |
| db_wr_no | output | 1 | Daughterboard write strobe, active low |
| db_addr_o | output | 6 | Daughterboard address |
| db_data_i | input | 8 | Resolved daughterboard data level |
| db_data_o | output | 8 | Data driven to the daughterboard |
| db_data_oe_o | output | 1 | Daughterboard data output-enable |
| db_spare_o | output | 1 | Spare control line value |
| db_spare_oe_o | output | 1 | Spare control line output-enable |
| db_spare_i | input | 1 | Sensed spare line level |
| power_o | output | 1 | Daughterboard power request |

## Verification
The bench models both data buses with weak pulls and counts the drivers on each bus. A bridge that got the direction wrong would either fight the far side or leave the receiver reading the pull value. Selected cycles with both strobes low, or with neither strobe low, are aimed at decoders that test only one strobe; such a decoder would drive the bus while the processor drives it too. Disabled cycles with active strobes catch a bridge that keeps driving an unpowered board. The spare line has a pull-down on the bench, so a bridge that leaves the spare line driven after disable shows up in the status byte. Writes that set only the ignored control bits catch a register that decodes the wrong bit positions.

// File: rtl/db_bridge_pkg.sv
package db_bridge_pkg;
  localparam int unsigned CFG_W     = 8;
  localparam int unsigned EN_BIT    = 1;
  localparam int unsigned SPARE_BIT = 4;

  typedef enum logic [1:0] {
    XFER_OFF  = 2'd0,
    XFER_IDLE = 2'd1,
    XFER_RD   = 2'd2,
    XFER_WR   = 2'd3
  } xfer_e;
endpackage

// File: rtl/db_bridge_cfg_reg.sv
module db_bridge_cfg_reg
  import db_bridge_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             en_o,
  output logic             spare_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      spare_o <= 1'b0;
    end else if (we_i) begin
      en_o    <= wdata_i[EN_BIT];
      spare_o <= wdata_i[SPARE_BIT];
    end
  end
endmodule

// File: rtl/db_bridge_dir_ctrl.sv
module db_bridge_dir_ctrl
  import db_bridge_pkg::*;
(
  input  logic  en_i,
  input  logic  cs_ni,
  input  logic  oe_ni,
  input  logic  we_ni,
  output xfer_e xfer_o
);
  always_comb begin
    if (!en_i)                      xfer_o = XFER_OFF;
    else if (cs_ni)                 xfer_o = XFER_IDLE;
    else if (!oe_ni && we_ni)       xfer_o = XFER_RD;
    else if (!we_ni && oe_ni)       xfer_o = XFER_WR;
    else                            xfer_o = XFER_IDLE; // both or neither strobe
  end
endmodule

// File: rtl/db_bridge_status.sv
module db_bridge_status
  import db_bridge_pkg::*;
(
  input  logic             en_i,
  input  logic             spare_lvl_i,
  output logic [CFG_W-1:0] rdata_o
);
  always_comb begin
    rdata_o            = '0;
    rdata_o[EN_BIT]    = en_i;
    rdata_o[SPARE_BIT] = spare_lvl_i;
  end
endmodule

// File: rtl/db_bridge.sv
module db_bridge
  import db_bridge_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o,
  input  logic              eb_cs_ni,
  input  logic              eb_oe_ni,
  input  logic              eb_we_ni,
  input  logic [ADDR_W-1:0] eb_addr_i,
  input  logic [DATA_W-1:0] eb_data_i,
  output logic [DATA_W-1:0] eb_data_o,
  output logic              eb_data_oe_o,
  output logic              db_ctl_oe_o,
  output logic              db_rd_no,
  output logic              db_wr_no,
  output logic [ADDR_W-1:0] db_addr_o,
  input  logic [DATA_W-1:0] db_data_i,
  output logic [DATA_W-1:0] db_data_o,
  output logic              db_data_oe_o,
  output logic              db_spare_o,
  output logic              db_spare_oe_o,
  input  logic              db_spare_i,
  output logic              power_o
);
  logic  en_q, spare_q;
  xfer_e xfer;
  logic  xfer_act;

  db_bridge_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .en_o    (en_q),
    .spare_o (spare_q)
  );

  db_bridge_dir_ctrl u_dir (
    .en_i   (en_q),
    .cs_ni  (eb_cs_ni),
    .oe_ni  (eb_oe_ni),
    .we_ni  (eb_we_ni),
    .xfer_o (xfer)
  );

  db_bridge_status u_sts (
    .en_i        (en_q),
    .spare_lvl_i (db_spare_i),
    .rdata_o     (cfg_rdata_o)
  );

  assign xfer_act      = (xfer == XFER_RD) || (xfer == XFER_WR);
  assign power_o       = en_q;
  assign db_ctl_oe_o   = (xfer != XFER_OFF);
  assign db_rd_no      = (xfer != XFER_RD);
  assign db_wr_no      = (xfer != XFER_WR);
  assign db_addr_o     = xfer_act ? eb_addr_i : '0;
  assign db_data_o     = eb_data_i;
  assign db_data_oe_o  = (xfer == XFER_WR);
  assign eb_data_o     = db_data_i;
  assign eb_data_oe_o  = (xfer == XFER_RD);
  assign db_spare_o    = spare_q;
  assign db_spare_oe_o = en_q;
endmodule

// File: rtl/db_bridge_chk.sv
module db_bridge_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [7:0]        cfg_wdata_i,
  input logic              eb_cs_ni,
  input logic              eb_oe_ni,
  input logic              eb_we_ni,
  input logic [ADDR_W-1:0] eb_addr_i,
  input logic              eb_data_oe_o,
  input logic              db_ctl_oe_o,
  input logic              db_rd_no,
  input logic              db_wr_no,
  input logic [ADDR_W-1:0] db_addr_o,
  input logic              db_data_oe_o,
  input logic              db_spare_oe_o,
  input logic              power_o
);
  p_disabled_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_o |-> !(db_ctl_oe_o || db_data_oe_o || db_spare_oe_o || eb_data_oe_o));

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_o && eb_cs_ni) |-> (db_rd_no && db_wr_no && db_addr_o == '0 && !db_data_oe_o && !eb_data_oe_o));

  p_read_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_o && !eb_cs_ni && !eb_oe_ni && eb_we_ni) |-> (!db_rd_no && eb_data_oe_o && db_addr_o == eb_addr_i));

  p_write_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (power_o && !eb_cs_ni && !eb_we_ni && eb_oe_ni) |-> (!db_wr_no && db_data_oe_o && db_addr_o == eb_addr_i));

  p_both_low_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eb_oe_ni && !eb_we_ni) |-> (!db_data_oe_o && !eb_data_oe_o));

  p_cfg_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (power_o == $past(cfg_wdata_i[1])));

  p_no_contend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(db_data_oe_o && eb_data_oe_o));

  p_spare_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_spare_oe_o == power_o);
endmodule

bind db_bridge db_bridge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_wdata_i   (cfg_wdata_i),
  .eb_cs_ni      (eb_cs_ni),
  .eb_oe_ni      (eb_oe_ni),
  .eb_we_ni      (eb_we_ni),
  .eb_addr_i     (eb_addr_i),
  .eb_data_oe_o  (eb_data_oe_o),
  .db_ctl_oe_o   (db_ctl_oe_o),
  .db_rd_no      (db_rd_no),
  .db_wr_no      (db_wr_no),
  .db_addr_o     (db_addr_o),
  .db_data_oe_o  (db_data_oe_o),
  .db_spare_oe_o (db_spare_oe_o),
  .power_o       (power_o)
);

// File: tb/db_bridge_tb.sv
module db_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  typedef struct packed {
    logic       en;
    logic       cs_n;
    logic       oe_n;
    logic       we_n;
    logic [5:0] addr;
    logic [7:0] cpu_d;
    logic [7:0] dev_d;
    logic [1:0] mode;   // 0 float, 1 idle, 2 read, 3 write
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b0, 1'b0, 1'b1, 6'h15, 8'h00, 8'h77, 2'd0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 6'h0A, 8'h3C, 8'h00, 2'd0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 6'h2A, 8'h00, 8'h11, 2'd1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'h2A, 8'h00, 8'h5A, 2'd2},
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'h3F, 8'hC3, 8'h00, 2'd3},
    '{1'b1, 1'b0, 1'b0, 1'b0, 6'h07, 8'h99, 8'h66, 2'd1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 6'h21, 8'h00, 8'h00, 2'd1},
    '{1'b1, 1'b0, 1'b0, 1'b1, 6'h01, 8'h00, 8'hA5, 2'd2},
    '{1'b1, 1'b1, 1'b1, 1'b0, 6'h12, 8'h44, 8'h00, 2'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic eb_cs_n = 1'b1, eb_oe_n = 1'b1, eb_we_n = 1'b1;
  logic [5:0] eb_addr = '0;
  logic [7:0] cpu_val = '0, dev_val = '0;
  logic [7:0] eb_bus, eb_drv_d, db_bus, db_drv_d;
  logic eb_drv_oe, db_ctl_oe, db_rd_n, db_wr_n, db_drv_oe;
  logic [5:0] db_addr;
  logic spare_d, spare_oe, spare_pin, power;
  logic cpu_drv, dev_drv;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // weak pull-ups on both data buses, pull-down on spare line
  assign cpu_drv   = !eb_cs_n && !eb_we_n;
  assign dev_drv   = db_ctl_oe && !db_rd_n;
  assign eb_bus    = eb_drv_oe ? eb_drv_d : (cpu_drv ? cpu_val : 8'hFF);
  assign db_bus    = db_drv_oe ? db_drv_d : (dev_drv ? dev_val : 8'hFF);
  assign spare_pin = spare_oe ? spare_d : 1'b0;

  db_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .eb_cs_ni(eb_cs_n), .eb_oe_ni(eb_oe_n), .eb_we_ni(eb_we_n),
    .eb_addr_i(eb_addr), .eb_data_i(eb_bus), .eb_data_o(eb_drv_d), .eb_data_oe_o(eb_drv_oe),
    .db_ctl_oe_o(db_ctl_oe), .db_rd_no(db_rd_n), .db_wr_no(db_wr_n), .db_addr_o(db_addr),
    .db_data_i(db_bus), .db_data_o(db_drv_d), .db_data_oe_o(db_drv_oe),
    .db_spare_o(spare_d), .db_spare_oe_o(spare_oe), .db_spare_i(spare_pin),
    .power_o(power)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    summary();
  end

  initial begin
    logic cur_en;
    logic [3:0] drv_eb, drv_db;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cfg_rdata == 8'h00, "R1 status", cfg_rdata, 8'h00);
    check({power, db_ctl_oe, db_drv_oe, spare_oe, eb_drv_oe} == 5'b0, "R1 outputs",
          {power, db_ctl_oe, db_drv_oe, spare_oe, eb_drv_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cur_en = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      if (v.en != cur_en) begin
        write_cfg({6'b0, v.en, 1'b0});
        cur_en = v.en;
      end
      eb_cs_n = v.cs_n; eb_oe_n = v.oe_n; eb_we_n = v.we_n;
      eb_addr = v.addr; cpu_val = v.cpu_d; dev_val = v.dev_d;
      #(CLK_PERIOD/4);
      drv_eb = 4'(eb_drv_oe) + 4'(cpu_drv);
      drv_db = 4'(db_drv_oe) + 4'(dev_drv);
      check(drv_eb <= 1 && drv_db <= 1, "R10 single driver", {drv_eb, drv_db}, 0);
      check(power == v.en, "R11 power", power, v.en);
      case (v.mode)
        2'd0: check({db_ctl_oe, db_drv_oe, spare_oe, eb_drv_oe} == 4'b0, "R2 float",
                    {db_ctl_oe, db_drv_oe, spare_oe, eb_drv_oe}, 0);
        2'd1: begin
          check(db_ctl_oe && db_rd_n && db_wr_n && db_addr == 6'h0,
                v.cs_n ? "R3 idle" : "R6 idle", {db_ctl_oe, db_rd_n, db_wr_n, db_addr}, 9'h1C0);
          check(!db_drv_oe && !eb_drv_oe, v.cs_n ? "R3 data off" : "R6 data off",
                {db_drv_oe, eb_drv_oe}, 0);
        end
        2'd2: begin
          check(!db_rd_n && db_wr_n && db_addr == v.addr, "R4 strobe/addr",
                {db_rd_n, db_wr_n, db_addr}, {2'b01, v.addr});
          check(eb_bus == v.dev_d && !db_drv_oe, "R4 data", eb_bus, v.dev_d);
        end
        default: begin
          check(!db_wr_n && db_rd_n && db_addr == v.addr, "R5 strobe/addr",
                {db_rd_n, db_wr_n, db_addr}, {2'b10, v.addr});
          check(db_bus == v.cpu_d && !eb_drv_oe, "R5 data", db_bus, v.cpu_d);
        end
      endcase
      @(negedge clk);
    end

    eb_cs_n = 1'b1; eb_oe_n = 1'b1; eb_we_n = 1'b1;
    // R8 ignored bits only: disables, spare low
    write_cfg(8'hED);
    #1;
    check(cfg_rdata == 8'h00 && !power, "R8 ignored bits", cfg_rdata, 8'h00);
    // R7/R9 enable with spare high
    write_cfg(8'h12);
    #1;
    check(spare_oe && spare_d, "R7 spare drive", {spare_oe, spare_d}, 2'b11);
    check(cfg_rdata == 8'h12, "R9 status", cfg_rdata, 8'h12);
    write_cfg(8'h02);
    #1;
    check(spare_oe && !spare_d && cfg_rdata == 8'h02, "R7 spare low", cfg_rdata, 8'h02);
    // disabled with spare bit set: line floats to pull-down
    write_cfg(8'h10);
    #1;
    check(!spare_oe && cfg_rdata == 8'h00, "R7 spare float", {spare_oe, cfg_rdata}, 0);
    check(!power && !db_ctl_oe, "R2 after disable", {power, db_ctl_oe}, 0);
    // R1 async reset clears an enabled config
    write_cfg(8'h12);
    rst_n = 1'b0;
    #1;
    check(!power && cfg_rdata == 8'h00, "R1 async reset", cfg_rdata, 8'h00);
    summary();
  end
endmodule